// File: doc/BRIEF.md
# Lock-Qualified Reset Sequencer

This block produces the start-up reset for a chip region fed by several clock managers. It runs entirely on the free-running reference clock. It never uses a derived clock, because such clocks may be missing or unstable while reset is active. After the external reset request is removed, the block holds the clock managers in reset for a fixed settling interval. It then releases them and watches their lock flags.

Each lock flag is resynchronised and then filtered. A flag counts as qualified only after it has read high without a break for a programmable number of cycles. The downstream system reset is released only when every flag is qualified. If any qualified flag later drops, system reset is asserted again and qualification starts over.

A strap input selects a fallback mode. In that mode the lock flags are ignored and system reset is released after a fixed worst-case lock time. When clock managers are chained, with one's lock feeding the next one's reset, the clock-manager reset output goes only to the first of them.

Top module: `lock_reset_seq`

## Requirements
- R1: While `ext_rst_n` is low, `cm_rst` is 1, `sys_rst_n` is 0 and `lock_qual` is all zeros. A falling `ext_rst_n` takes effect at the outputs without waiting for a clock edge.
- R2: The release of `ext_rst_n` is resynchronised through two reference-clock flops before the sequencer starts counting.
- R3: `cm_rst` falls on the (SETTLE_CYC+2)-th rising edge after `ext_rst_n` rises. `sys_rst_n` is never 1 while `cm_rst` is 1.
- R4: Each `lock_in[i]` passes through a two-flop synchroniser. Bit i of `lock_qual` rises only after the synchronised flag has been high for QUAL_CYC consecutive cycles, which is QUAL_CYC+2 edges after `lock_in[i]` rises.
- R5: A single low sample of a synchronised lock flag clears its count and its `lock_qual` bit. A high pulse shorter than QUAL_CYC therefore never qualifies, and counting restarts from the last rise.
- R6: With `timeout_mode` = 0, `sys_rst_n` stays 0 while any `lock_qual` bit is 0. It rises on the edge after all N bits are 1, which is QUAL_CYC+3 edges after the last lock flag rises.
- R7: With `timeout_mode` = 0 and system reset released, a lock flag that falls makes `sys_rst_n` go to 0 on the 4th rising edge after the fall. Release then needs a full new qualification.
- R8: With `timeout_mode` = 1, `sys_rst_n` rises TIMEOUT_CYC edges after `cm_rst` falls, whatever the lock flags do. A later lock drop does not assert system reset again.
- R9: Lock counts are held at zero while `cm_rst` is 1. Flags that are already high during settling give a release QUAL_CYC+1 edges after `cm_rst` falls.
- R10: `lock_qual[i]` reports the qualified state of `lock_in[i]` in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Always-present reference clock; the only clock in the block |
| ext_rst_n | input | 1 | External reset request, active low, asynchronous assertion |
| timeout_mode | input | 1 | Strap: 1 selects the timeout-only release, 0 the lock-qualified release; hold static while out of reset |
| lock_in | input | N_LOCK | Asynchronous lock flags from the clock managers, bit i per manager |
| cm_rst | output | 1 | Active-high reset to the first clock manager in the chain |
| sys_rst_n | output | 1 | Active-low system reset, released synchronously to `ref_clk` |
| lock_qual | output | N_LOCK | Per-flag qualified status |

## Verification
On every cycle the assertions check four things:
- a qualified bit rises only after a synchronised high sample taken outside the settling phase;
- a qualified bit clears on the cycle after a low sample;
- a lock counter never passes its limit;
- system reset is never released during settling, and in lock mode never without all flags qualified in the previous cycle.

The exact edge counts (settling length, qualification latency, timeout length and the reaction delay to a lock drop) can only be shown by the bench scenarios. The same holds for the rejection of a short glitch and the indifference of timeout mode to the flags, which the bench measures from the ports.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_WAIT   = 2'd1,
    ST_RUN    = 2'd2
  } seq_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lrs_rst_sync.sv
// Reset bridge: asserts asynchronously, releases after STAGES clock edges.
module lrs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_req_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_req_n) begin
    if (!arst_req_n) chain_q <= '0;
    else             chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lrs_sync.sv
// Multi-bit level synchroniser, each bit independent.
module lrs_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/lrs_lock_filter.sv
// Per-flag qualification: the flag must stay high QUAL_CYC cycles in a row.
module lrs_lock_filter #(
  parameter int unsigned QUAL_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic lock_s,
  output logic qual
);
  localparam int unsigned CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] QUAL_LIM = CW'(QUAL_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr || !lock_s) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != QUAL_LIM) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qual = (cnt_q == QUAL_LIM);

  // R4
  qual_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual) |-> ($past(lock_s) && !$past(clr)));

  // R5
  qual_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !lock_s) |=> !qual);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= QUAL_LIM);
endmodule

// File: rtl/lrs_seq_fsm.sv
// Settle / wait-for-lock / run sequencer with a timeout fallback.
module lrs_seq_fsm
  import lrs_pkg::*;
#(
  parameter int unsigned SETTLE_CYC  = 16,
  parameter int unsigned TIMEOUT_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout_mode,
  input  logic all_qual,
  output logic cm_rst,
  output logic sys_rst_n
);
  localparam int unsigned MAXC = max_u(SETTLE_CYC, TIMEOUT_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETTLE_LAST  = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] TIMEOUT_LAST = CW'(TIMEOUT_CYC - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cm_rst_q, cm_rst_d;
  logic          sys_q, sys_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (timeout_mode) begin
          if (cnt_q == TIMEOUT_LAST) begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (all_qual) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (!timeout_mode && !all_qual) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = ST_SETTLE;
        cnt_d   = '0;
      end
    endcase
    cm_rst_d = (state_d == ST_SETTLE);
    sys_d    = (state_d == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SETTLE;
      cnt_q    <= '0;
      cm_rst_q <= 1'b1;
      sys_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      cm_rst_q <= cm_rst_d;
      sys_q    <= sys_d;
    end
  end

  assign cm_rst    = cm_rst_q;
  assign sys_rst_n = sys_q;

  // R6
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_q && !timeout_mode) |-> $past(all_qual));

  // R3
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_q) |-> (!cm_rst_q && $past(!cm_rst_q)));
endmodule

// File: rtl/lock_reset_seq.sv
module lock_reset_seq #(
  parameter int unsigned N_LOCK      = 2,
  parameter int unsigned SETTLE_CYC  = 16,
  parameter int unsigned QUAL_CYC    = 8,
  parameter int unsigned TIMEOUT_CYC = 40
) (
  input  logic              ref_clk,
  input  logic              ext_rst_n,
  input  logic              timeout_mode,
  input  logic [N_LOCK-1:0] lock_in,
  output logic              cm_rst,
  output logic              sys_rst_n,
  output logic [N_LOCK-1:0] lock_qual
);
  localparam int unsigned SYNC_STAGES = 2;

  logic              rst_n_i;
  logic [N_LOCK-1:0] lock_s;
  logic [N_LOCK-1:0] qual_v;
  logic              cm_rst_i;

  lrs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (ref_clk),
    .arst_req_n (ext_rst_n),
    .rst_n      (rst_n_i)
  );

  lrs_sync #(.W(N_LOCK), .STAGES(SYNC_STAGES)) u_lock_sync (
    .clk     (ref_clk),
    .rst_n   (rst_n_i),
    .d_async (lock_in),
    .q_sync  (lock_s)
  );

  for (genvar i = 0; i < N_LOCK; i++) begin : g_filt
    lrs_lock_filter #(.QUAL_CYC(QUAL_CYC)) u_filt (
      .clk    (ref_clk),
      .rst_n  (rst_n_i),
      .clr    (cm_rst_i),
      .lock_s (lock_s[i]),
      .qual   (qual_v[i])
    );
  end

  lrs_seq_fsm #(.SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk          (ref_clk),
    .rst_n        (rst_n_i),
    .timeout_mode (timeout_mode),
    .all_qual     (&qual_v),
    .cm_rst       (cm_rst_i),
    .sys_rst_n    (sys_rst_n)
  );

  assign cm_rst    = cm_rst_i;
  assign lock_qual = qual_v;
endmodule

// File: tb/test_lock_reset_seq.sv
`timescale 1ns/1ps
module test_lock_reset_seq;
  localparam int N = 2;
  localparam int S = 16;
  localparam int Q = 8;
  localparam int T = 40;

  logic         clk = 1'b0;
  logic         ext_rst_n;
  logic         tmode;
  logic [N-1:0] lock_in;
  logic         cm_rst;
  logic         sys_rst_n;
  logic [N-1:0] lock_qual;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  lock_reset_seq #(.N_LOCK(N), .SETTLE_CYC(S), .QUAL_CYC(Q), .TIMEOUT_CYC(T)) i_lock_reset_seq (
    .ref_clk      (clk),
    .ext_rst_n    (ext_rst_n),
    .timeout_mode (tmode),
    .lock_in      (lock_in),
    .cm_rst       (cm_rst),
    .sys_rst_n    (sys_rst_n),
    .lock_qual    (lock_qual)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic meas_cm_fall(output int n);
    n = 0;
    while (cm_rst !== 1'b0 && n < 1000) begin @(posedge clk); #1; n++; end
  endtask

  task automatic meas_sys_rise(output int n);
    n = 0;
    while (sys_rst_n !== 1'b1 && n < 1000) begin @(posedge clk); #1; n++; end
  endtask

  task automatic meas_sys_fall(output int n);
    n = 0;
    while (sys_rst_n !== 1'b0 && n < 1000) begin @(posedge clk); #1; n++; end
  endtask

  task automatic enter_reset(input logic mode, input logic [N-1:0] locks);
    @(negedge clk);
    ext_rst_n = 1'b0;
    tmode     = mode;
    lock_in   = locks;
    edges(4);
  endtask

  // R1 reset state
  task automatic t_reset;
    enter_reset(1'b0, '0);
    chk("R1", "cm_rst in reset", int'(cm_rst), 1);
    chk("R1", "sys_rst_n in reset", int'(sys_rst_n), 0);
    chk("R1", "lock_qual in reset", int'(lock_qual), 0);
  endtask

  // R2 R3 R4 R6 R10: lock-mode bring-up
  task automatic t_lock_bringup;
    int n;
    @(negedge clk); ext_rst_n = 1'b1;
    meas_cm_fall(n);
    chk("R3", "edges to cm_rst fall (R2 sync incl.)", n, S + 2);
    edges(20);
    chk("R6", "sys_rst_n held with no locks", int'(sys_rst_n), 0);
    @(negedge clk); lock_in[0] = 1'b1;
    edges(Q + 1);
    chk("R4", "lock_qual[0] not yet at Q+1", int'(lock_qual[0]), 0);
    edges(1);
    chk("R4", "lock_qual[0] at Q+2", int'(lock_qual[0]), 1);
    edges(3);
    chk("R10", "lock_qual with one lock", int'(lock_qual), 1);
    chk("R6", "sys_rst_n held with one lock", int'(sys_rst_n), 0);
    @(negedge clk); lock_in[1] = 1'b1;
    meas_sys_rise(n);
    chk("R6", "edges from last lock to release", n, Q + 3);
    chk("R10", "lock_qual both locked", int'(lock_qual), 3);
    chk("R3", "cm_rst low after release", int'(cm_rst), 0);
  endtask

  // R5 R7: drop after release and glitch rejection
  task automatic t_drop_glitch;
    int n;
    @(negedge clk); lock_in[0] = 1'b0;
    meas_sys_fall(n);
    chk("R7", "edges from lock drop to reassert", n, 4);
    chk("R7", "lock_qual after drop", int'(lock_qual), 2);
    @(negedge clk); lock_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    lock_in[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5", "sys_rst_n during short glitch", int'(sys_rst_n), 0);
    chk("R5", "lock_qual[0] during short glitch", int'(lock_qual[0]), 0);
    lock_in[0] = 1'b1;
    meas_sys_rise(n);
    chk("R5", "release counted from last rise", n, Q + 3);
  endtask

  // R9: locks high during settling
  task automatic t_early_lock;
    int n;
    enter_reset(1'b0, '1);
    @(negedge clk); ext_rst_n = 1'b1;
    meas_cm_fall(n);
    chk("R9", "cm_rst fall with early locks", n, S + 2);
    chk("R9", "lock_qual held clear in settle", int'(lock_qual), 0);
    meas_sys_rise(n);
    chk("R9", "edges from cm_rst fall to release", n, Q + 1);
  endtask

  // R1: asynchronous assertion
  task automatic t_async;
    @(posedge clk); #2;
    ext_rst_n = 1'b0;
    #0.5;
    chk("R1", "sys_rst_n async assert", int'(sys_rst_n), 0);
    chk("R1", "cm_rst async assert", int'(cm_rst), 1);
    chk("R1", "lock_qual async clear", int'(lock_qual), 0);
  endtask

  // R8 R10: timeout mode
  task automatic t_timeout;
    int n;
    enter_reset(1'b1, '0);
    @(negedge clk); ext_rst_n = 1'b1;
    meas_cm_fall(n);
    chk("R3", "cm_rst fall in timeout mode", n, S + 2);
    meas_sys_rise(n);
    chk("R8", "edges from cm_rst fall to timeout release", n, T);
    @(negedge clk); lock_in = '1;
    edges(Q + 4);
    chk("R10", "lock_qual in timeout mode", int'(lock_qual), 3);
    @(negedge clk); lock_in[0] = 1'b0;
    edges(10);
    chk("R8", "no reassert on drop in timeout mode", int'(sys_rst_n), 1);
    chk("R10", "lock_qual after drop in timeout mode", int'(lock_qual), 2);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    ext_rst_n = 1'b0;
    tmode     = 1'b0;
    lock_in   = '0;
    t_reset();
    t_lock_bringup();
    t_drop_glitch();
    t_async();
    t_early_lock();
    t_timeout();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule